// File: doc/BRIEF.md
# 3x3 Cluster Seed-Threshold Finder

This block sits behind a bank of column-parallel pixel converters. It reduces a full frame of pixel amplitudes to a short list of cluster candidates. Each readout step delivers one complete row, with a 3-bit amplitude for every column. The block keeps the most recent rows, builds a 3x3 neighbourhood around every pixel of the row in the middle, and tests each neighbourhood twice. The centre amplitude must reach a seed threshold. The total of all nine amplitudes must reach a separate, larger cluster threshold. A neighbourhood that passes both tests leaves the block as one record: the centre row, the centre column and all nine amplitudes.

Rows arrive on a valid/ready input and accepted clusters leave on a valid/ready output. After each accepted row the block walks across the columns at one column per clock, so it takes one clock per column plus one clock per cluster that the downstream side stalls. While it is walking, the input is not ready. At the end of a frame the block pushes one zero row through on its own, which closes out the last row. It then starts the next frame at row 0. Both thresholds are registers, and a single write strobe loads them.

Top module: `cluster_seed_finder`

## Requirements
- R1: After reset the input is ready (`row_ready`=1), no cluster is offered (`cl_valid`=0), and the thresholds hold seed 2 and cluster 6.
- R2: A clock edge with `cfg_wr`=1 loads `cfg_seed` and `cfg_clus` as the new thresholds. The new values apply to every neighbourhood examined afterwards.
- R3: A neighbourhood is reported only if its centre amplitude is greater than or equal to the seed threshold. A centre exactly equal to the threshold passes, and one below it does not.
- R4: A neighbourhood is reported only if the unsigned sum of its nine amplitudes is greater than or equal to the cluster threshold. Both R3 and R4 must hold together.
- R5: Pixels beyond the first or last row or column count as amplitude 0. A neighbourhood is examined for every pixel of the frame, including corners and edges.
- R6: `cl_pix` holds the nine amplitudes at 3 bits each. Slot k = 3*dr + dc occupies bits [3k+2:3k], where dr 0/1/2 is the row above, the centre row and the row below, and dc 0/1/2 is the column left, centre and right. `cl_row` and `cl_col` give the position of the centre pixel.
- R7: Clusters leave in row-major order of their centre (row ascending, then column ascending). A frame is NROWS accepted rows, and the next accepted row is row 0 of a new frame.
- R8: While `cl_valid`=1 and `cl_ready`=0, the next cycle still shows `cl_valid`=1 with unchanged `cl_row`, `cl_col` and `cl_pix`.
- R9: `row_ready` is 0 whenever a cluster is being offered. A row transfers only on a clock edge with `row_valid` and `row_ready` both high.
- R10: With `cl_ready` held high, the neighbourhood centred on column 0 of row r is offered in the first cycle after the edge that accepts row r+1. Each later column follows one cycle after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Threshold load strobe |
| cfg_seed | input | 3 | New seed threshold |
| cfg_clus | input | 6 | New cluster threshold |
| row_valid | input | 1 | Row offered |
| row_ready | output | 1 | Row can be taken |
| row_pix | input | NCOLS*3 | Row amplitudes, column c at bits [3c+2:3c] |
| cl_valid | output | 1 | Cluster offered |
| cl_ready | input | 1 | Downstream takes the cluster |
| cl_row | output | ROW_W | Centre row of the cluster |
| cl_col | output | COL_W | Centre column of the cluster |
| cl_pix | output | 27 | Nine amplitudes, layout per R6 |

## Verification
The results for centre row r depend on row r+1, so none of them can appear before the edge that accepts row r+1. From that edge, column c is offered c cycles later plus any cycles the output was stalled. Centre row NROWS-1 comes one cycle later again, after the internal zero row has been pushed in. The bench samples one time unit after each rising edge. It decides both handshakes from the values it sees at that point, and a transfer counts only at the following edge. It times R10 from the recorded acceptance cycle, and it checks the held record on the sample after each stall.

// File: rtl/csf_pkg.sv
`timescale 1ns/1ps
package csf_pkg;

    localparam int PIX_W    = 3;
    localparam int WIN_N    = 9;
    localparam int PIX_MAX  = (1 << PIX_W) - 1;
    localparam int SUM_W    = $clog2(WIN_N * PIX_MAX + 1);

    typedef logic [PIX_W-1:0]            pix_t;
    typedef logic [SUM_W-1:0]            sum_t;
    typedef logic [WIN_N-1:0][PIX_W-1:0] win_t;

    typedef struct packed {
        sum_t clus;
        pix_t seed;
    } thr_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_FLUSH
    } scan_st_t;

    localparam pix_t SEED_DEF = pix_t'(2);
    localparam sum_t CLUS_DEF = sum_t'(6);

    localparam int CENTRE = 4;

    function automatic sum_t win_sum(input win_t w);
        sum_t s;
        s = '0;
        for (int k = 0; k < WIN_N; k++) begin
            s = s + sum_t'(w[k]);
        end
        return s;
    endfunction

endpackage

// File: rtl/csf_thr_regs.sv
`timescale 1ns/1ps
module csf_thr_regs
    import csf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  pix_t seed_in,
    input  sum_t clus_in,
    output thr_t thr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr.seed <= SEED_DEF;
            thr.clus <= CLUS_DEF;
        end else if (wr) begin
            thr.seed <= seed_in;
            thr.clus <= clus_in;
        end
    end

endmodule

// File: rtl/csf_line_buf.sv
`timescale 1ns/1ps
module csf_line_buf
    import csf_pkg::*;
#(
    parameter  int NCOLS = 64,
    localparam int RW    = NCOLS * PIX_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 shift,
    input  logic                 shift_zero,
    input  logic [RW-1:0]        row_in,
    output logic [2:0][RW-1:0]   rows
);

    // rows[0] is the oldest (above centre), rows[2] the newest (below)
    logic [RW-1:0] incoming;

    always_comb begin
        incoming = shift_zero ? '0 : row_in;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rows <= '0;
        end else if (shift) begin
            rows[0] <= rows[1];
            rows[1] <= rows[2];
            rows[2] <= incoming;
        end
    end

endmodule

// File: rtl/csf_window.sv
`timescale 1ns/1ps
module csf_window
    import csf_pkg::*;
#(
    parameter  int NCOLS = 64,
    localparam int RW    = NCOLS * PIX_W,
    localparam int COL_W = (NCOLS > 1) ? $clog2(NCOLS) : 1
) (
    input  logic [2:0][RW-1:0] rows,
    input  logic [COL_W-1:0]   col,
    input  thr_t               thr,
    output win_t               win,
    output logic               hit
);

    sum_t total;
    logic seed_ok;
    logic clus_ok;

    always_comb begin
        for (int r = 0; r < 3; r++) begin
            for (int d = 0; d < 3; d++) begin
                int idx;
                idx = int'(col) + d - 1;
                if (idx < 0 || idx >= NCOLS) begin
                    win[r*3 + d] = '0;
                end else begin
                    win[r*3 + d] = pix_t'(rows[r] >> (idx * PIX_W));
                end
            end
        end
    end

    always_comb begin
        total   = win_sum(win);
        seed_ok = (win[CENTRE] >= thr.seed);
        clus_ok = (total >= thr.clus);
        hit     = seed_ok && clus_ok;
    end

endmodule

// File: rtl/csf_scan_ctrl.sv
`timescale 1ns/1ps
module csf_scan_ctrl
    import csf_pkg::*;
#(
    parameter  int NROWS  = 100,
    parameter  int NCOLS  = 64,
    localparam int ROW_W  = (NROWS > 1) ? $clog2(NROWS) : 1,
    localparam int COL_W  = (NCOLS > 1) ? $clog2(NCOLS) : 1,
    localparam int RCNT_W = $clog2(NROWS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             row_valid,
    output logic             row_ready,
    output logic             shift,
    output logic             shift_zero,
    output logic             clear,
    input  logic             hit,
    output logic             cl_valid,
    input  logic             cl_ready,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] cen_row
);

    scan_st_t          st;
    logic [RCNT_W-1:0] rcnt;
    logic              flushing;
    logic              accept;
    logic              adv;
    logic              last_col;

    always_comb begin
        row_ready  = (st == ST_IDLE);
        accept     = row_valid && row_ready;
        shift      = accept || (st == ST_FLUSH);
        shift_zero = (st == ST_FLUSH);
        cl_valid   = (st == ST_SCAN) && hit;
        adv        = (st == ST_SCAN) && (!hit || cl_ready);
        last_col   = (col == COL_W'(NCOLS - 1));
        clear      = adv && last_col && flushing;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            rcnt     <= '0;
            flushing <= 1'b0;
            col      <= '0;
            cen_row  <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        rcnt <= rcnt + 1'b1;
                        if (rcnt != '0) begin
                            st      <= ST_SCAN;
                            col     <= '0;
                            cen_row <= ROW_W'(rcnt - 1'b1);
                        end else if (NROWS == 1) begin
                            st <= ST_FLUSH;
                        end
                    end
                end
                ST_SCAN: begin
                    if (adv) begin
                        if (!last_col) begin
                            col <= col + 1'b1;
                        end else if (flushing) begin
                            st       <= ST_IDLE;
                            flushing <= 1'b0;
                            rcnt     <= '0;
                        end else if (rcnt == RCNT_W'(NROWS)) begin
                            st <= ST_FLUSH;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_FLUSH: begin
                    st       <= ST_SCAN;
                    col      <= '0;
                    cen_row  <= ROW_W'(NROWS - 1);
                    flushing <= 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cluster_seed_finder.sv
`timescale 1ns/1ps
module cluster_seed_finder
    import csf_pkg::*;
#(
    parameter  int NROWS = 100,
    parameter  int NCOLS = 64,
    localparam int ROW_W = (NROWS > 1) ? $clog2(NROWS) : 1,
    localparam int COL_W = (NCOLS > 1) ? $clog2(NCOLS) : 1,
    localparam int RW    = NCOLS * PIX_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_wr,
    input  logic [PIX_W-1:0]       cfg_seed,
    input  logic [SUM_W-1:0]       cfg_clus,
    input  logic                   row_valid,
    output logic                   row_ready,
    input  logic [RW-1:0]          row_pix,
    output logic                   cl_valid,
    input  logic                   cl_ready,
    output logic [ROW_W-1:0]       cl_row,
    output logic [COL_W-1:0]       cl_col,
    output logic [WIN_N*PIX_W-1:0] cl_pix
);

    thr_t              thr_q;
    logic [2:0][RW-1:0] rows;
    logic              shift;
    logic              shift_zero;
    logic              clear;
    logic              hit;
    win_t              win;
    logic [COL_W-1:0]  col;
    logic [ROW_W-1:0]  cen_row;

    csf_thr_regs u_thr (
        .clk     (clk),
        .rst     (rst),
        .wr      (cfg_wr),
        .seed_in (cfg_seed),
        .clus_in (cfg_clus),
        .thr     (thr_q)
    );

    csf_line_buf #(.NCOLS(NCOLS)) u_lbuf (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .shift      (shift),
        .shift_zero (shift_zero),
        .row_in     (row_pix),
        .rows       (rows)
    );

    csf_window #(.NCOLS(NCOLS)) u_win (
        .rows (rows),
        .col  (col),
        .thr  (thr_q),
        .win  (win),
        .hit  (hit)
    );

    csf_scan_ctrl #(.NROWS(NROWS), .NCOLS(NCOLS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .row_valid  (row_valid),
        .row_ready  (row_ready),
        .shift      (shift),
        .shift_zero (shift_zero),
        .clear      (clear),
        .hit        (hit),
        .cl_valid   (cl_valid),
        .cl_ready   (cl_ready),
        .col        (col),
        .cen_row    (cen_row)
    );

    always_comb begin
        cl_row = cen_row;
        cl_col = col;
        cl_pix = win;
    end

endmodule

// File: rtl/csf_checker.sv
`timescale 1ns/1ps
module csf_checker
    import csf_pkg::*;
#(
    parameter  int NROWS = 100,
    parameter  int NCOLS = 64,
    localparam int ROW_W = (NROWS > 1) ? $clog2(NROWS) : 1,
    localparam int COL_W = (NCOLS > 1) ? $clog2(NCOLS) : 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   row_ready,
    input logic                   cl_valid,
    input logic                   cl_ready,
    input logic [ROW_W-1:0]       cl_row,
    input logic [COL_W-1:0]       cl_col,
    input logic [WIN_N*PIX_W-1:0] cl_pix,
    input thr_t                   thr
);

    win_t out_win;
    always_comb out_win = cl_pix;

    a_r1_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (row_ready && !cl_valid));

    a_r3_seed_met: assert property (@(posedge clk) disable iff (rst)
        cl_valid |-> (out_win[CENTRE] >= thr.seed));

    a_r4_sum_met: assert property (@(posedge clk) disable iff (rst)
        cl_valid |-> (win_sum(out_win) >= thr.clus));

    a_r7_in_frame: assert property (@(posedge clk) disable iff (rst)
        cl_valid |-> ((int'(cl_row) < NROWS) && (int'(cl_col) < NCOLS)));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (cl_valid && !cl_ready) |=>
        (cl_valid && $stable(cl_row) && $stable(cl_col) && $stable(cl_pix)));

    a_r9_busy: assert property (@(posedge clk) disable iff (rst)
        cl_valid |-> !row_ready);

endmodule

bind cluster_seed_finder csf_checker #(.NROWS(NROWS), .NCOLS(NCOLS)) u_csf_chk (
    .clk       (clk),
    .rst       (rst),
    .row_ready (row_ready),
    .cl_valid  (cl_valid),
    .cl_ready  (cl_ready),
    .cl_row    (cl_row),
    .cl_col    (cl_col),
    .cl_pix    (cl_pix),
    .thr       (thr_q)
);

// File: tb/test_cluster_seed_finder.sv
`timescale 1ns/1ps
module test_cluster_seed_finder;

    localparam int NR  = 4;
    localparam int NC  = 8;
    localparam int RW  = NC * 3;
    localparam int NF  = 7;
    localparam int MAXE = NR * NC;

    // frame table: seed, cluster threshold, image (row r at bits [24r+23:24r])
    localparam logic [2:0]  T_SEED [NF] = '{3'd1, 3'd5, 3'd4, 3'd5, 3'd0, 3'd3, 3'd6};
    localparam logic [5:0]  T_CLUS [NF] = '{6'd1, 6'd7, 6'd4, 6'd4, 6'd0, 6'd20, 6'd1};
    localparam logic [95:0] T_IMG  [NF] = '{
        96'h000000_000000_000000_000000,
        96'h000000_000000_000E00_000000,
        96'h000000_000000_000000_000004,
        96'h000000_000000_000000_000004,
        96'h5A3C71_9E0F2B_C4D861_37A5E2,
        96'hFFF000_123456_654321_ABCDEF,
        96'hE40000_000000_000000_000000
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_seed = '0;
    logic [5:0]    cfg_clus = '0;
    logic          row_valid = 1'b0;
    logic          row_ready;
    logic [RW-1:0] row_pix = '0;
    logic          cl_valid;
    logic          cl_ready = 1'b1;
    logic [1:0]    cl_row;
    logic [2:0]    cl_col;
    logic [26:0]   cl_pix;

    always #2 clk = ~clk;

    cluster_seed_finder #(.NROWS(NR), .NCOLS(NC)) i_cluster_seed_finder (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_seed(cfg_seed),
        .cfg_clus(cfg_clus), .row_valid(row_valid), .row_ready(row_ready),
        .row_pix(row_pix), .cl_valid(cl_valid), .cl_ready(cl_ready),
        .cl_row(cl_row), .cl_col(cl_col), .cl_pix(cl_pix)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int acc_cyc = 0;
    logic acc;
    logic stall_mode = 1'b0;
    logic prev_stall = 1'b0;
    logic [1:0]  sv_row;
    logic [2:0]  sv_col;
    logic [26:0] sv_pix;
    logic [1:0]  e_row [MAXE];
    logic [2:0]  e_col [MAXE];
    logic [26:0] e_pix [MAXE];
    int n_exp = 0;
    int n_got = 0;
    logic done = 1'b0;

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] px(input logic [95:0] img, input int r, input int c);
        if (r < 0 || r >= NR || c < 0 || c >= NC) return 3'd0;
        return img[r*RW + c*3 +: 3];
    endfunction

    task automatic build_exp(input logic [95:0] img, input logic [2:0] sd, input logic [5:0] cs);
        n_exp = 0;
        n_got = 0;
        for (int r = 0; r < NR; r++) begin
            for (int c = 0; c < NC; c++) begin
                logic [26:0] w;
                int s;
                s = 0;
                for (int dr = 0; dr < 3; dr++) begin
                    for (int dc = 0; dc < 3; dc++) begin
                        w[(dr*3+dc)*3 +: 3] = px(img, r+dr-1, c+dc-1);
                        s += int'(px(img, r+dr-1, c+dc-1));
                    end
                end
                if (px(img, r, c) >= sd && s >= int'(cs)) begin
                    e_row[n_exp] = 2'(r);
                    e_col[n_exp] = 3'(c);
                    e_pix[n_exp] = w;
                    n_exp++;
                end
            end
        end
    endtask

    // evaluate handshakes at current sample, then advance one clock
    task automatic step();
        if (prev_stall) begin
            check(cl_valid && cl_row == sv_row && cl_col == sv_col && cl_pix == sv_pix,
                  "R8", "held record", {cl_row, cl_col, cl_pix}, {sv_row, sv_col, sv_pix});
        end
        if (cl_valid) begin
            check(!row_ready, "R9", "row_ready while offering", 32'(row_ready), 0);
        end
        if (cl_valid && cl_ready) begin
            if (n_got < n_exp) begin
                check(cl_row == e_row[n_got] && cl_col == e_col[n_got], "R7",
                      "cluster position", {cl_row, cl_col}, {e_row[n_got], e_col[n_got]});
                check(cl_pix == e_pix[n_got], "R6", "cluster amplitudes",
                      32'(cl_pix), 32'(e_pix[n_got]));
                if (!stall_mode && cl_col == 0 && int'(cl_row) < NR-1) begin
                    check(cyc == acc_cyc + 1, "R10", "first column latency",
                          32'(cyc - acc_cyc), 1);
                end
            end else begin
                check(1'b0, "R3", "unexpected cluster", {cl_row, cl_col}, 0);
            end
            n_got++;
        end
        prev_stall = cl_valid && !cl_ready;
        sv_row = cl_row; sv_col = cl_col; sv_pix = cl_pix;
        if (row_valid && row_ready) begin
            acc = 1'b1;
            acc_cyc = cyc;
        end
        @(posedge clk); #1;
        cyc++;
        cl_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
    endtask

    task automatic send_row(input logic [RW-1:0] d);
        row_pix = d;
        row_valid = 1'b1;
        acc = 1'b0;
        while (!acc) step();
        row_valid = 1'b0;
    endtask

    task automatic run_frame(input logic [95:0] img, input string req);
        for (int r = 0; r < NR; r++) send_row(img[r*RW +: RW]);
        for (int i = 0; i < 6*NC + 8; i++) step();
        check(n_got == n_exp, req, "cluster count", 32'(n_got), 32'(n_exp));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        row_valid = 1'b0;
        prev_stall = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        do_reset();
        // R1: reset state
        check(row_ready == 1'b1, "R1", "row_ready after reset", 32'(row_ready), 1);
        check(cl_valid == 1'b0, "R1", "cl_valid after reset", 32'(cl_valid), 0);

        // R1: default thresholds seed 2 / cluster 6 apply before any write
        build_exp(T_IMG[5], 3'd2, 6'd6);
        run_frame(T_IMG[5], "R1");

        // table walk: R2 load, R3/R4 tests, R5 edges, R7 framing, R8 stalls
        for (int f = 0; f < NF; f++) begin
            stall_mode = f[0];
            cfg_seed = T_SEED[f];
            cfg_clus = T_CLUS[f];
            cfg_wr = 1'b1;
            @(posedge clk); #1;
            cfg_wr = 1'b0;
            build_exp(T_IMG[f], T_SEED[f], T_CLUS[f]);
            run_frame(T_IMG[f], (f == 2) ? "R4" : (f == 3) ? "R3" : (f == 6) ? "R5" : "R2");
        end

        // R9: while walking a row, the input refuses the next row
        stall_mode = 1'b0;
        cfg_seed = 3'd0; cfg_clus = 6'd0; cfg_wr = 1'b1;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        build_exp(T_IMG[4], 3'd0, 6'd0);
        send_row(T_IMG[4][0 +: RW]);
        check(row_ready == 1'b1, "R9", "ready after first row", 32'(row_ready), 1);
        send_row(T_IMG[4][RW +: RW]);
        check(row_ready == 1'b0, "R9", "busy while walking", 32'(row_ready), 0);
        send_row(T_IMG[4][2*RW +: RW]);
        send_row(T_IMG[4][3*RW +: RW]);
        for (int i = 0; i < 6*NC + 8; i++) step();
        check(n_got == n_exp, "R7", "cluster count with back-to-back rows", 32'(n_got), 32'(n_exp));

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule